// File: doc/BRIEF.md
# Store buffer with read bypass

This block sits between one processor port and a shared memory port. A processor write is taken into a small queue in the cycle it is presented, so the processor can go on to its next access without waiting out the slow memory write. The queue sends its entries to memory one at a time, oldest first. A buffered write does not reach shared memory until memory acknowledges it.

A processor read whose address is not held in the queue goes to memory as soon as the memory port is idle. It can therefore overtake older writes that are still queued. A read whose address matches any queued write stalls the processor until every matching entry has been acknowledged. The read then fetches the value from memory. Queued data is never forwarded to a read. Two instances that share one memory can therefore both read the other's flag as 0 after each has written its own flag.

The processor holds a request until `cpu_gnt_o` is high. A write is granted in the same cycle when the queue has room. A read is granted in the cycle its memory acknowledge arrives, and the read data is valid in that cycle. The memory port holds each request and its fields until a one-cycle `mem_ack_i`.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the queue is empty and `mem_req_o` is 0.
- R2: A processor write is granted in the same cycle it is requested while fewer than DEPTH (default 4) entries are pending, so back-to-back writes complete one per cycle.
- R3: While DEPTH entries are pending, a write is not granted. It is granted only after a memory write acknowledge frees an entry.
- R4: Queued writes are issued to memory oldest first, with at most one memory access outstanding. `mem_req_o`, `mem_we_o` (1 = write), `mem_addr_o` and `mem_wdata_o` stay stable until `mem_ack_i`.
- R5: An entry leaves the queue only on the acknowledge of its memory write. Until then another port reading that address sees the old memory value.
- R6: A read whose address matches no pending entry is issued when the memory port is idle, even if older writes are still queued. A read wins over starting a drain.
- R7: A read that arrives while a memory write is in flight waits until that write is acknowledged.
- R8: A read whose address matches one or more pending entries is not sent to memory until the youngest matching entry has been acknowledged. It then returns the value of that youngest write.
- R9: A write to an address that is already pending is granted without stalling and queued behind the earlier one.
- R10: A read is granted in the cycle of its memory acknowledge, and `cpu_rdata_o` carries the memory read data in that cycle.
- R11: Two instances on one memory, each writing its own flag and then reading the other's, can both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until granted |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_gnt_o | output | 1 | Request accepted (write queued, or read data valid) |
| cpu_rdata_o | output | DATA_W | Read data, valid with a read grant |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | One-cycle memory completion |
| mem_rdata_i | input | DATA_W | Memory read data, valid with acknowledge |

## Verification
Write grants are due in the same cycle as the request. A memory access starts one clock after the port is seen idle. Writes are acknowledged 100 cycles after issue and reads 2 cycles after issue. A read grant therefore follows its issuing edge by two cycles. A behavioural model with queues in the bench tracks every one of these clock edges. The bench compares the memory port and the grant against that model at each falling edge, once inputs and the acknowledge have settled. Directed tests measure grant latencies in whole cycles to separate a bypassing read (a few cycles) from a stalled one (about 100).

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WR   = 2'd1,
    SEQ_RD   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [ADDR_W-1:0]              push_addr_i,
  input  logic [DATA_W-1:0]              push_data_i,
  input  logic                           pop_i,
  output logic                           full_o,
  output logic                           empty_o,
  output logic [ADDR_W-1:0]              head_addr_o,
  output logic [DATA_W-1:0]              head_data_o,
  output logic [DEPTH-1:0]               slot_valid_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             valid_q;
  logic [PTR_W-1:0]             wr_ptr_q, rd_ptr_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      data_q   <= '0;
      valid_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) begin
        addr_q[wr_ptr_q]  <= push_addr_i;
        data_q[wr_ptr_q]  <= push_data_i;
        valid_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q          <= ptr_inc(wr_ptr_q);
      end
      if (pop_i) begin
        valid_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q          <= ptr_inc(rd_ptr_q);
      end
    end
  end

  assign full_o       = &valid_q;
  assign empty_o      = ~|valid_q;
  assign head_addr_o  = addr_q[rd_ptr_q];
  assign head_data_o  = data_q[rd_ptr_q];
  assign slot_valid_o = valid_q;
  assign slot_addr_o  = addr_q;
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic [DEPTH-1:0]             slot_valid_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic                         hit_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = slot_valid_i[g] && (slot_addr_i[g] == rd_addr_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/sb_seq.sv
module sb_seq
  import sb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              rd_hit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              q_empty_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              pop_o,
  output logic              rd_done_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          // idle port: a clean read beats starting a drain
          if (rd_req_i && !rd_hit_i) begin
            state_q <= SEQ_RD;
            addr_q  <= rd_addr_i;
          end else if (!q_empty_i) begin
            state_q <= SEQ_WR;
            addr_q  <= head_addr_i;
            data_q  <= head_data_i;
          end
        end
        SEQ_WR, SEQ_RD: if (mem_ack_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q != SEQ_IDLE);
  assign mem_we_o    = (state_q == SEQ_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign pop_o       = (state_q == SEQ_WR) && mem_ack_i;
  assign rd_done_o   = (state_q == SEQ_RD) && mem_ack_i;
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_gnt_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic                         push, pop, q_full, q_empty, rd_hit, rd_done, rd_req;
  logic [ADDR_W-1:0]            head_addr;
  logic [DATA_W-1:0]            head_data;
  logic [DEPTH-1:0]             q_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] q_addr;

  assign rd_req = cpu_req_i && !cpu_we_i;
  assign push   = cpu_req_i && cpu_we_i && !q_full;

  sb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_queue (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(cpu_addr_i), .push_data_i(cpu_wdata_i),
    .pop_i(pop), .full_o(q_full), .empty_o(q_empty),
    .head_addr_o(head_addr), .head_data_o(head_data),
    .slot_valid_o(q_valid), .slot_addr_o(q_addr)
  );

  sb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .slot_valid_i(q_valid), .slot_addr_i(q_addr),
    .rd_addr_i(cpu_addr_i), .hit_o(rd_hit)
  );

  sb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni,
    .rd_req_i(rd_req), .rd_hit_i(rd_hit), .rd_addr_i(cpu_addr_i),
    .q_empty_i(q_empty), .head_addr_i(head_addr), .head_data_i(head_data),
    .mem_ack_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .pop_o(pop), .rd_done_o(rd_done)
  );

  assign cpu_gnt_o   = cpu_we_i ? push : (rd_req && rd_done);
  assign cpu_rdata_o = mem_rdata_i;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_we_i,
  input logic              cpu_gnt_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              rd_hit,
  input logic [DEPTH-1:0]  q_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_req_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o && cpu_we_i && !(mem_ack_i && mem_we_o)
      |=> $countones(q_valid) == $past($countones(q_valid)) + 1);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &q_valid |-> !(cpu_gnt_o && cpu_we_i));

  assert_retire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i && !(cpu_gnt_o && cpu_we_i)
      |=> $countones(q_valid) == $past($countones(q_valid)) - 1);

  assert_read_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !rd_hit);

  assert_read_gnt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o && !cpu_we_i |-> mem_req_o && !mem_we_o && mem_ack_i);
endmodule

bind sb_store_buffer sb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .cpu_we_i, .cpu_gnt_o, .mem_req_o, .mem_we_o,
  .mem_addr_o, .mem_wdata_o, .mem_ack_i, .rd_hit, .q_valid
);

// File: tb/tb_sb_store_buffer.sv
module tb_sb_store_buffer;
  localparam int DEPTH = 4, AW = 4, DW = 8;
  localparam int WR_LAT = 100, RD_LAT = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [1:0]   req, we, gnt, m_req, m_we, m_ack;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [AW-1:0] m_addr [2];
  logic [DW-1:0] m_wdata [2];
  logic [DW-1:0] m_rdata [2];
  logic [DW-1:0] shmem [16];
  int mcnt [2];

  int checks = 0, errors = 0;

  for (genvar g = 0; g < 2; g++) begin : g_cpu
    assign m_ack[g]   = m_req[g] && (mcnt[g] == (m_we[g] ? WR_LAT : RD_LAT) - 1);
    assign m_rdata[g] = shmem[m_addr[g]];
    if (g == 0) begin : g_dut
      sb_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req[g]), .cpu_we_i(we[g]),
        .cpu_addr_i(addr[g]), .cpu_wdata_i(wdata[g]), .cpu_gnt_o(gnt[g]),
        .cpu_rdata_o(rdata[g]), .mem_req_o(m_req[g]), .mem_we_o(m_we[g]),
        .mem_addr_o(m_addr[g]), .mem_wdata_o(m_wdata[g]), .mem_ack_i(m_ack[g]),
        .mem_rdata_i(m_rdata[g]));
    end else begin : g_peer
      sb_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req[g]), .cpu_we_i(we[g]),
        .cpu_addr_i(addr[g]), .cpu_wdata_i(wdata[g]), .cpu_gnt_o(gnt[g]),
        .cpu_rdata_o(rdata[g]), .mem_req_o(m_req[g]), .mem_we_o(m_we[g]),
        .mem_addr_o(m_addr[g]), .mem_wdata_o(m_wdata[g]), .mem_ack_i(m_ack[g]),
        .mem_rdata_i(m_rdata[g]));
    end
  end

  // shared memory: fixed latency, write visible only at its acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) shmem[a] <= '0;
      shmem[8] <= 8'h5A;
      mcnt[0] <= 0; mcnt[1] <= 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        mcnt[i] <= (m_req[i] && !m_ack[i]) ? mcnt[i] + 1 : 0;
        if (m_ack[i] && m_we[i]) shmem[m_addr[i]] <= m_wdata[i];
      end
    end
  end

  // behavioural reference: pending writes as queues, port as a small state
  logic [AW+DW-1:0] mq [2][$];
  int               mst [2];   // 0 idle, 1 write, 2 read
  logic [AW+DW-1:0] mcur [2];

  function automatic bit m_hit(int i);
    foreach (mq[i][k]) if (mq[i][k][AW+DW-1:DW] == addr[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin mq[i].delete(); mst[i] = 0; mcur[i] = '0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit acc;
        acc = req[i] && we[i] && (mq[i].size() < DEPTH);
        if (mst[i] == 1 && m_ack[i]) begin void'(mq[i].pop_front()); mst[i] = 0; end
        else if (mst[i] == 2 && m_ack[i]) mst[i] = 0;
        else if (mst[i] == 0) begin
          if (req[i] && !we[i] && !m_hit(i)) begin mst[i] = 2; mcur[i] = {addr[i], 8'h00}; end
          else if (mq[i].size() > 0) begin mst[i] = 1; mcur[i] = mq[i][0]; end
        end
        if (acc) mq[i].push_back({addr[i], wdata[i]});
      end
    end
  end

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 2; i++) begin
      bit eg;
      eg = req[i] && (we[i] ? (mq[i].size() < DEPTH) : (mst[i] == 2 && m_ack[i]));
      chk(m_req[i] == (mst[i] != 0), "R4 mem_req", m_req[i], mst[i] != 0);
      if (mst[i] != 0) begin
        chk(m_we[i] == (mst[i] == 1), "R6 mem_we", m_we[i], mst[i] == 1);
        chk(m_addr[i] == mcur[i][AW+DW-1:DW], "R4 mem_addr", m_addr[i], mcur[i][AW+DW-1:DW]);
        if (mst[i] == 1) chk(m_wdata[i] == mcur[i][DW-1:0], "R4 mem_wdata", m_wdata[i], mcur[i][DW-1:0]);
      end
      chk(gnt[i] == eg, we[i] ? "R3 write grant" : "R8 read grant", gnt[i], eg);
    end
  end

  // holds request until grant; entered and left at posedge+1
  task automatic op(int i, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                    output logic [DW-1:0] rd, output int cyc);
    req[i] = 1; we[i] = w; addr[i] = a; wdata[i] = d; cyc = 0;
    forever begin
      @(negedge clk); cyc++;
      if (gnt[i]) break;
    end
    rd = rdata[i];
    @(posedge clk); #1 req[i] = 0;
  endtask

  task automatic drain();
    while (mq[0].size() != 0 || mq[1].size() != 0 || mst[0] != 0 || mst[1] != 0)
      @(posedge clk);
    #1;
  endtask

  task automatic run();
    logic [DW-1:0] r0, r1;
    int c0, c1;
    req = '0; we = '0; addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
    #23;
    chk(m_req == 2'b00, "R1 reset idle", m_req, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(m_req == 2'b00, "R1 after reset", m_req, 0);

    // R11 / R6: both flags written, both reads bypass and see 0
    fork
      begin op(0, 1, 4'd1, 8'd1, r0, c0); op(0, 0, 4'd2, 0, r0, c0); end
      begin op(1, 1, 4'd2, 8'd1, r1, c1); op(1, 0, 4'd1, 0, r1, c1); end
    join
    chk(r0 == 0, "R11 cpu0 reads peer flag", r0, 0);
    chk(r1 == 0, "R11 cpu1 reads peer flag", r1, 0);
    chk(c0 < 10, "R6 bypass latency", c0, 3);
    drain();
    chk(shmem[1] == 1 && shmem[2] == 1, "R4 flags committed", shmem[1], 1);

    // R5 / R8: pending write invisible to peer, own read stalls then sees it
    fork
      begin op(0, 1, 4'd3, 8'd5, r0, c0); repeat (8) @(posedge clk); #1; op(0, 0, 4'd3, 0, r0, c0); end
      begin repeat (4) @(posedge clk); #1; op(1, 0, 4'd3, 0, r1, c1); end
    join
    chk(r1 == 0, "R5 peer sees old value", r1, 0);
    chk(r0 == 5, "R8 stalled read value", r0, 5);
    chk(c0 > 50, "R8 stall length", c0, 90);
    drain();

    // R2 / R9 / R3: fill with repeats, overflow write waits for a retire
    op(0, 1, 4'd5, 8'd1, r0, c0); chk(c0 == 1, "R2 write 1 cycle", c0, 1);
    op(0, 1, 4'd5, 8'd2, r0, c0); chk(c0 == 1, "R9 same-address write", c0, 1);
    op(0, 1, 4'd6, 8'd3, r0, c0); chk(c0 == 1, "R2 write 1 cycle", c0, 1);
    op(0, 1, 4'd5, 8'd4, r0, c0); chk(c0 == 1, "R9 same-address write", c0, 1);
    op(0, 1, 4'd9, 8'd9, r0, c0); chk(c0 > 50, "R3 full stalls write", c0, 97);
    op(0, 0, 4'd5, 0, r0, c0);
    chk(r0 == 4, "R8 youngest match value", r0, 4);
    chk(c0 > 150, "R8 waits for youngest", c0, 300);
    drain();
    chk(shmem[5] == 4 && shmem[6] == 3 && shmem[9] == 9, "R4 in-order commit", shmem[5], 4);

    // R7 / R10: read behind an in-flight write waits, then returns memory data
    op(0, 1, 4'd7, 8'd7, r0, c0);
    repeat (10) @(posedge clk); #1;
    op(0, 0, 4'd8, 0, r0, c0);
    chk(c0 > 80, "R7 read waits for write ack", c0, 91);
    chk(r0 == 8'h5A, "R10 read data", r0, 8'h5A);
    drain();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule